// File: doc/BRIEF.md
# Parallel Flash Command Sequencer with Bit-5/Bit-7 Lane Exchange

This block sits between a host and a byte-wide parallel flash device that is controlled through a command register. The host asks for one operation at a time: array read, identify, erase, program or reset. It gives an address and, for program, a data byte. The sequencer then runs the bus write and read cycles the device expects. For program and erase it also writes a programming-voltage control register before and after the operation.

Data bits 5 and 7 are crossed between the sequencer and the device. Every byte the sequencer puts on the data pins is therefore pre-exchanged, and every byte it reads back is exchanged again before use. After a program or erase it verifies the result and repeats the operation up to a fixed number of attempts. When the operation ends it pulses `done` and reports a pass flag and the read data.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done`, `req_ack`, `fl_dq_oe` and `vpp_we` are 0, and `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1.
- R2: A request is acknowledged (`req_ack`=1) only while `busy` is 0. While `busy` is 1 a request gets no acknowledge and causes no bus cycle. `busy` stays 1 from acceptance until `done` pulses for exactly one cycle.
- R3: Every byte on `fl_dq_o` is the logical byte with bits 5 and 7 exchanged, and every byte read from `fl_dq_i` is exchanged back. Erase setup appears on the pins as 0x80, program-verify as 0x60, identify as 0x30, while 0xA0, 0x40, 0x00 and 0xFF are unchanged.
- R4: Operation code 0 (read) writes command 0x00 to the request address, then reads that address. The byte is returned in `rdata[7:0]` with `rdata[15:8]`=0 and `pass`=1.
- R5: Operation code 1 (identify) writes 0x90 to address 0, then reads address 0 and then address 1. It returns `rdata`={first,second}, and `pass`=1 only when that equals 16'h89B4.
- R6: Operation code 2 (erase) writes 0x20 twice, then writes 0xA0 to the request address and reads it back. The attempt passes when the read byte is 0xFF.
- R7: Operation code 3 (program) writes 0x40, then writes the data byte to the request address, then writes 0xC0 and reads that address. The attempt passes when the read byte equals the data byte, which is returned in `rdata[7:0]`.
- R8: When an erase or program verify fails, the whole command sequence repeats. After MAX_TRY failed attempts the operation ends with `pass`=0 and the last read byte in `rdata[7:0]`.
- R9: Erase and program are preceded by one `vpp_we` pulse with `vpp_data`=0x01. They are followed by pulses with 0x02 and then 0x03, at least VPP_DLY cycles of wait, and a pulse with 0x06. Read, identify and reset produce no `vpp_we` pulse.
- R10: Operation code 4 (reset) writes 0xFF twice and returns `pass`=1.
- R11: A write cycle holds `fl_we_n` low for exactly WE_W cycles, only while `fl_ce_n` is low and `fl_dq_oe` is 1, with address and data unchanged at its rising edge. A read cycle holds `fl_oe_n` low for exactly RD_W cycles with `fl_dq_oe`=0. `fl_we_n` and `fl_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 3 | Operation: 0 read, 1 identify, 2 erase, 3 program, 4 reset |
| req_addr | input | AW | Target address |
| req_wdata | input | 8 | Program data byte |
| req_ack | output | 1 | Request taken this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| pass | output | 1 | Result flag, valid from done until next acceptance |
| rdata | output | 16 | Read / identifier / verify data |
| fl_addr | output | AW | Device address |
| fl_dq_o | output | 8 | Data driven to device pins |
| fl_dq_oe | output | 1 | Data pin drive enable |
| fl_dq_i | input | 8 | Data from device pins |
| fl_ce_n | output | 1 | Device chip enable, active low |
| fl_oe_n | output | 1 | Device output enable, active low |
| fl_we_n | output | 1 | Device write enable, active low |
| vpp_we | output | 1 | Programming-voltage register write strobe |
| vpp_data | output | 8 | Programming-voltage register value |

## Verification
The bench uses a device model that decodes standard command codes only after undoing the lane crossing. A sequencer that forgets to pre-exchange bits 5 and 7 therefore sends the model wrong commands, and its erase and program verifies fail. Identifier bytes are chosen so that an unexchanged read turns 0x89 into 0x29. The model can be told to ignore a number of program or erase attempts. With that, the bench checks that a retry restarts the full command sequence: an off-by-one attempt limit shows as the wrong count of pin writes or a wrong pass flag. A request raised mid-operation must leave the pin-write count untouched, and the voltage register sequence and the strobe widths are measured against their parameters.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW      = 17,
  parameter int WE_W    = 4,
  parameter int RD_W    = 3,
  parameter int VPP_DLY = 1000,
  parameter int MAX_TRY = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          req_ack,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [15:0]   rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic          vpp_we,
  output logic [7:0]    vpp_data
);
  localparam int CW = $clog2(VPP_DLY + WE_W + RD_W + 2);
  localparam int TW = $clog2(MAX_TRY + 1);
  localparam logic [CW-1:0] WE_LAST  = CW'(WE_W - 1);
  localparam logic [CW-1:0] RD_LAST  = CW'(RD_W - 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(VPP_DLY - 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRY - 1);

  localparam logic [2:0] OP_READ = 3'd0, OP_IDENT = 3'd1, OP_ERASE = 3'd2,
                         OP_PROG = 3'd3, OP_RESET = 3'd4;
  localparam logic [1:0] A_REQ = 2'd0, A_ZERO = 2'd1, A_ONE = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_DISP, S_WSET, S_WPUL, S_WHLD, S_READ, S_DLY} st_t;
  typedef enum logic [2:0] {K_WR, K_RD, K_VPP, K_WAIT, K_CHK, K_END} kind_t;

  function automatic logic [7:0] lane_x(input logic [7:0] b);
    return {b[5], b[6], b[7], b[4:0]};
  endfunction

  st_t           state;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [3:0]    step;
  logic [TW-1:0] tries;
  logic [CW-1:0] cnt;
  logic [7:0]    cap_hi, cap_lo;
  logic          chk_ok;

  kind_t         kind;
  logic [7:0]    cbyte;
  logic [1:0]    asel;
  logic          to_hi;
  logic [AW-1:0] sel_addr;
  logic [7:0]    expect_b;

  assign busy     = (state != S_IDLE);
  assign req_ack  = req_valid && (state == S_IDLE);
  assign expect_b = (op_q == OP_ERASE) ? 8'hFF : data_q;
  assign sel_addr = (asel == A_ZERO) ? '0 :
                    (asel == A_ONE)  ? AW'(1) : addr_q;

  always_comb begin
    kind  = K_END;
    cbyte = 8'h00;
    asel  = A_REQ;
    to_hi = 1'b0;
    case (op_q)
      OP_READ: begin
        case (step)
          4'd0: begin kind = K_WR; cbyte = 8'h00; end
          4'd1: kind = K_RD;
          default: kind = K_END;
        endcase
      end
      OP_IDENT: begin
        case (step)
          4'd0: begin kind = K_WR; cbyte = 8'h90; asel = A_ZERO; end
          4'd1: begin kind = K_RD; asel = A_ZERO; to_hi = 1'b1; end
          4'd2: begin kind = K_RD; asel = A_ONE; end
          default: kind = K_END;
        endcase
      end
      OP_ERASE, OP_PROG: begin
        case (step)
          4'd0: begin kind = K_VPP; cbyte = 8'h01; end
          4'd1: begin kind = K_WR; cbyte = (op_q == OP_ERASE) ? 8'h20 : 8'h40; end
          4'd2: begin kind = K_WR; cbyte = (op_q == OP_ERASE) ? 8'h20 : data_q; end
          4'd3: begin kind = K_WR; cbyte = (op_q == OP_ERASE) ? 8'hA0 : 8'hC0; end
          4'd4: kind = K_RD;
          4'd5: kind = K_CHK;
          4'd6: begin kind = K_VPP; cbyte = 8'h02; end
          4'd7: begin kind = K_VPP; cbyte = 8'h03; end
          4'd8: kind = K_WAIT;
          4'd9: begin kind = K_VPP; cbyte = 8'h06; end
          default: kind = K_END;
        endcase
      end
      OP_RESET: begin
        case (step)
          4'd0, 4'd1: begin kind = K_WR; cbyte = 8'hFF; end
          default: kind = K_END;
        endcase
      end
      default: kind = K_END;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      step     <= '0;
      tries    <= '0;
      cnt      <= '0;
      cap_hi   <= '0;
      cap_lo   <= '0;
      chk_ok   <= 1'b0;
      done     <= 1'b0;
      pass     <= 1'b0;
      rdata    <= '0;
      fl_addr  <= '0;
      fl_dq_o  <= '0;
      fl_dq_oe <= 1'b0;
      fl_ce_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
      fl_we_n  <= 1'b1;
      vpp_we   <= 1'b0;
      vpp_data <= '0;
    end else begin
      done   <= 1'b0;
      vpp_we <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          addr_q <= req_addr;
          data_q <= req_wdata;
          step   <= '0;
          tries  <= '0;
          cap_hi <= '0;
          cap_lo <= '0;
          chk_ok <= 1'b0;
          pass   <= 1'b0;
          state  <= S_DISP;
        end
        S_DISP: begin
          case (kind)
            K_WR: begin
              fl_addr  <= sel_addr;
              fl_dq_o  <= lane_x(cbyte);
              fl_dq_oe <= 1'b1;
              fl_ce_n  <= 1'b0;
              state    <= S_WSET;
            end
            K_RD: begin
              fl_addr  <= sel_addr;
              fl_dq_oe <= 1'b0;
              fl_ce_n  <= 1'b0;
              fl_oe_n  <= 1'b0;
              cnt      <= '0;
              state    <= S_READ;
            end
            K_VPP: begin
              vpp_we   <= 1'b1;
              vpp_data <= cbyte;
              step     <= step + 4'd1;
            end
            K_WAIT: begin
              cnt   <= '0;
              state <= S_DLY;
            end
            K_CHK: begin
              if (cap_lo == expect_b) begin
                chk_ok <= 1'b1;
                step   <= step + 4'd1;
              end else if (tries == TRY_LAST) begin
                chk_ok <= 1'b0;
                step   <= step + 4'd1;
              end else begin
                tries <= tries + 1'b1;
                step  <= 4'd1;
              end
            end
            default: begin
              done  <= 1'b1;
              rdata <= {cap_hi, cap_lo};
              case (op_q)
                OP_IDENT:         pass <= (cap_hi == 8'h89) && (cap_lo == 8'hB4);
                OP_ERASE, OP_PROG: pass <= chk_ok;
                default:          pass <= 1'b1;
              endcase
              state <= S_IDLE;
            end
          endcase
        end
        S_WSET: begin
          fl_we_n <= 1'b0;
          cnt     <= '0;
          state   <= S_WPUL;
        end
        S_WPUL: begin
          if (cnt == WE_LAST) begin
            fl_we_n <= 1'b1;
            state   <= S_WHLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WHLD: begin
          fl_ce_n  <= 1'b1;
          fl_dq_oe <= 1'b0;
          step     <= step + 4'd1;
          state    <= S_DISP;
        end
        S_READ: begin
          if (cnt == RD_LAST) begin
            if (to_hi) cap_hi <= lane_x(fl_dq_i);
            else       cap_lo <= lane_x(fl_dq_i);
            fl_ce_n <= 1'b1;
            fl_oe_n <= 1'b1;
            step    <= step + 4'd1;
            state   <= S_DISP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DLY: begin
          if (cnt == DLY_LAST) begin
            step  <= step + 4'd1;
            state <= S_DISP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe));
  assert_ack_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> busy);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_vpp_in_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_we |-> busy);
  assert_we_under_ce_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_dq_oe));
  assert_no_we_oe_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));
  assert_read_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);
  assert_we_rise_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_o)));
endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int AW = 8, WE_W = 3, RD_W = 2, VPP_DLY = 20, MAX_TRY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ack, busy, done, pass;
  logic [15:0] rdata;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_o, fl_dq_i;
  logic fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n, vpp_we;
  logic [7:0] vpp_data;

  always #5 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .WE_W(WE_W), .RD_W(RD_W), .VPP_DLY(VPP_DLY), .MAX_TRY(MAX_TRY)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ack(req_ack), .busy(busy), .done(done), .pass(pass),
    .rdata(rdata), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .vpp_we(vpp_we), .vpp_data(vpp_data));

  int checks = 0, errors = 0;
  int cyc = 0;

  function automatic logic [7:0] xs(input logic [7:0] b);
    return {b[5], b[6], b[7], b[4:0]};
  endfunction

  // device model: standard codes after undoing the lane crossing
  logic [7:0] mem [256];
  typedef enum {M_ARR, M_ID, M_ESET, M_PSET, M_VER} mode_t;
  mode_t mode = M_ARR;
  int fail_prog = 0, fail_erase = 0;
  logic [7:0] wlog [32];
  logic [AW-1:0] walog [32];
  int wcnt = 0;
  logic [7:0] vlog [16];
  int vcyc [16];
  int vcnt = 0;
  int wlo = 0, olo = 0, bad_we = 0, bad_oe = 0;

  logic [7:0] dev_out;
  assign dev_out = (mode == M_ID) ? ((fl_addr == 0) ? 8'h89 : (fl_addr == 1) ? 8'hB4 : 8'h00)
                                  : mem[fl_addr];
  assign fl_dq_i = xs(dev_out);

  always @(posedge fl_we_n) if (fl_ce_n === 1'b0) begin
    logic [7:0] b;
    b = xs(fl_dq_o);
    if (wcnt < 32) begin wlog[wcnt] = fl_dq_o; walog[wcnt] = fl_addr; end
    wcnt++;
    if (mode == M_PSET) begin
      if (fail_prog > 0) fail_prog--;
      else mem[fl_addr] = mem[fl_addr] & b;
      mode = M_ARR;
    end else if (mode == M_ESET && b == 8'h20) begin
      if (fail_erase > 0) fail_erase--;
      else for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
      mode = M_ARR;
    end else begin
      case (b)
        8'h90: mode = M_ID;
        8'h20: mode = M_ESET;
        8'h40: mode = M_PSET;
        8'hA0, 8'hC0: mode = M_VER;
        default: mode = M_ARR;
      endcase
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (vpp_we === 1'b1) begin
      if (vcnt < 16) begin vlog[vcnt] = vpp_data; vcyc[vcnt] = cyc; end
      vcnt++;
    end
    if (fl_we_n === 1'b0) wlo++;
    else if (wlo != 0) begin if (wlo != WE_W) bad_we++; wlo = 0; end
    if (fl_oe_n === 1'b0) olo++;
    else if (olo != 0) begin if (olo != RD_W) bad_oe++; olo = 0; end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    int n;
    wcnt = 0; vcnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    #1;
    chk("R2 ack when idle", req_ack === 1'b1, req_ack, 1);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (done !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk("R2 done reached (watchdog)", n < 5000, n, 0);
  endtask

  task automatic t_reset_state;
    chk("R1 busy", busy === 1'b0, busy, 0);
    chk("R1 done", done === 1'b0, done, 0);
    chk("R1 strobes", {fl_ce_n, fl_oe_n, fl_we_n} === 3'b111, {fl_ce_n, fl_oe_n, fl_we_n}, 7);
    chk("R1 drive", {fl_dq_oe, vpp_we} === 2'b00, {fl_dq_oe, vpp_we}, 0);
  endtask

  task automatic t_read;
    mem[8'h21] = 8'h85;
    run_op(3'd0, 8'h21, 8'h00);
    chk("R4 read data", rdata === 16'h0085, rdata, 16'h0085);
    chk("R4 read pass", pass === 1'b1, pass, 1);
    chk("R4 one write", wcnt == 1 && wlog[0] == 8'h00, wcnt, 1);
    chk("R9 no vpp on read", vcnt == 0, vcnt, 0);
  endtask

  task automatic t_ident;
    run_op(3'd1, 8'h55, 8'h00);
    chk("R5 id data", rdata === 16'h89B4, rdata, 16'h89B4);
    chk("R5 id pass", pass === 1'b1, pass, 1);
    chk("R3 id code on pins", wlog[0] == 8'h30, wlog[0], 8'h30);
    chk("R5 id cmd addr", walog[0] == 0, walog[0], 0);
    chk("R9 no vpp on ident", vcnt == 0, vcnt, 0);
  endtask

  task automatic t_erase;
    mem[8'h40] = 8'h12;
    run_op(3'd2, 8'h40, 8'h00);
    chk("R6 erase pass", pass === 1'b1, pass, 1);
    chk("R6 write count", wcnt == 3, wcnt, 3);
    chk("R3 erase code pins", wlog[0] == 8'h80 && wlog[1] == 8'h80, {wlog[0], wlog[1]}, 16'h8080);
    chk("R3 verify code pins", wlog[2] == 8'hA0 && walog[2] == 8'h40, wlog[2], 8'hA0);
    chk("R9 vpp sequence", vcnt == 4 && vlog[0] == 8'h01 && vlog[1] == 8'h02 &&
        vlog[2] == 8'h03 && vlog[3] == 8'h06, vcnt, 4);
    chk("R9 vpp delay", vcnt == 4 && (vcyc[3] - vcyc[2]) >= VPP_DLY, vcyc[3] - vcyc[2], VPP_DLY);
    chk("R6 erased byte", mem[8'h40] == 8'hFF, mem[8'h40], 8'hFF);
  endtask

  task automatic t_program;
    run_op(3'd3, 8'h33, 8'h8C);
    chk("R7 program pass", pass === 1'b1, pass, 1);
    chk("R7 program rdata", rdata[7:0] === 8'h8C, rdata[7:0], 8'h8C);
    chk("R7 stored", mem[8'h33] == 8'h8C, mem[8'h33], 8'h8C);
    chk("R3 prog setup pins", wlog[0] == 8'h40, wlog[0], 8'h40);
    chk("R3 prog data pins", wlog[1] == xs(8'h8C) && walog[1] == 8'h33, wlog[1], xs(8'h8C));
    chk("R3 prog verify pins", wlog[2] == 8'h60, wlog[2], 8'h60);
    chk("R9 vpp bracket", vcnt == 4 && vlog[0] == 8'h01 && vlog[3] == 8'h06, vcnt, 4);
  endtask

  task automatic t_busy_ignore;
    int n;
    wcnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd3; req_addr = 8'h34; req_wdata = 8'h5A;
    @(negedge clk);
    req_op = 3'd4;
    #1;
    chk("R2 no ack while busy", req_ack === 1'b0 && busy === 1'b1, req_ack, 0);
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (done !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk("R2 ignored request no cycles", wcnt == 3 && pass === 1'b1, wcnt, 3);
    repeat (3) @(negedge clk);
    chk("R2 idle after op", busy === 1'b0 && wcnt == 3, wcnt, 3);
  endtask

  task automatic t_retry;
    fail_prog = 2;
    run_op(3'd3, 8'h50, 8'h3C);
    chk("R8 retry then pass", pass === 1'b1, pass, 1);
    chk("R8 retry writes", wcnt == 3 * MAX_TRY, wcnt, 3 * MAX_TRY);
    fail_prog = 9;
    run_op(3'd3, 8'h51, 8'h3C);
    chk("R8 limit fail", pass === 1'b0, pass, 0);
    chk("R8 limit writes", wcnt == 3 * MAX_TRY, wcnt, 3 * MAX_TRY);
    chk("R8 last read", rdata[7:0] === 8'hFF, rdata[7:0], 8'hFF);
    fail_prog = 0;
    mem[8'h60] = 8'h00;
    fail_erase = 9;
    run_op(3'd2, 8'h60, 8'h00);
    chk("R8 erase limit fail", pass === 1'b0 && wcnt == 3 * MAX_TRY, wcnt, 3 * MAX_TRY);
    fail_erase = 0;
  endtask

  task automatic t_reset_cmd;
    run_op(3'd4, 8'h00, 8'h00);
    chk("R10 reset writes", wcnt == 2 && wlog[0] == 8'hFF && wlog[1] == 8'hFF, wcnt, 2);
    chk("R10 reset pass", pass === 1'b1, pass, 1);
    chk("R9 no vpp on reset", vcnt == 0, vcnt, 0);
  endtask

  task automatic t_timing;
    chk("R11 write pulse width", bad_we == 0, bad_we, 0);
    chk("R11 read pulse width", bad_oe == 0, bad_oe, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_read();
    t_ident();
    t_erase();
    t_program();
    t_busy_ignore();
    t_retry();
    t_reset_cmd();
    t_timing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule